// File: doc/BRIEF.md
# Thread Interrupt Presenter

This block presents interrupts to a single hardware thread. Notifications arrive on a small input port, each tagged with a priority from 0 to 7, where a lower value is more favoured. The block records each one as a bit in a pending bitmap. It derives the most favoured pending priority from that bitmap. It raises an interrupt line toward the processor whenever that priority beats the thread's current priority threshold.

The processor side is a plain memory-mapped port that takes byte and halfword accesses. A window of eight bytes exposes the following:
- the notification status byte;
- the current priority threshold;
- the pending bitmap;
- the derived pending priority.

A halfword read at a dedicated offset performs the acknowledge. It returns the exception type and the accepted priority in one value. In the same access it moves the pending priority into the threshold and retires that pending bit.

Software acknowledges in a loop. It writes each returned priority back as the threshold and repeats until the type field reads zero. It then reopens the thread by writing 0xFF to the threshold. Only accesses flagged as coming from the owning thread may change the threshold or acknowledge.

Top module: `thread_presenter`

## Requirements
- R1: After reset the threshold reads 0x00, the pending bitmap reads 0x00, the pending priority reads 0xFF, the status byte reads 0x00 and `irq_o` is low.
- R2: A notification of priority n (0..7) sets bit n of the pending bitmap, which is read as a byte at offset 0x02.
- R3: The pending priority, read as a byte at offset 0x07, is the index of the lowest set bitmap bit, or 0xFF when the bitmap is empty.
- R4: `irq_o` is high, and the status byte at offset 0x00 reads 0x80 (type 2 = physical in bits 7:6), exactly when the pending priority is numerically below the threshold. Otherwise `irq_o` is low and the status byte reads 0x00.
- R5: An owner halfword read at offset 0x800 while R4's condition holds is an acknowledge. It returns type 2 in bits 15:14 and the pending priority in bits 7:0. From the next cycle the threshold equals that priority and its bitmap bit is clear.
- R6: An owner halfword read at 0x800 with R4's condition false returns type 0 in bits 15:14 and the current threshold in bits 7:0. It changes no state.
- R7: The threshold is written by an owner byte write at offset 0x01, or by an owner halfword write at offset 0x00, which takes its low byte. Writes and acknowledge reads from a non-owner change nothing, and a non-owner acknowledge read returns 0.
- R8: Byte reads at offsets 0x03 to 0x06 return 0. A halfword read at an even offset a below 8 returns byte a in bits 15:8 and byte a+1 in bits 7:0. A byte read at 0x800 returns 0 and has no side effect.
- R9: If a notification arrives in the same cycle as an acknowledge that retires the same priority, the bitmap bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntf_valid | input | 1 | Notification strobe |
| ntf_prio | input | 3 | Notification priority |
| bus_sel | input | 1 | CPU access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = halfword, 0 = byte |
| bus_owner | input | 1 | Access comes from the owning thread |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| irq_o | output | 1 | Interrupt request to the thread |

## Verification
The bench targets the acknowledge cases. An acknowledge with nothing pending must leave the bitmap untouched; a design that always retires a bit would silently lose an interrupt. A non-owner access must change nothing; a design that ignored ownership would let another thread lower the threshold or steal an acknowledge.

Equality between the pending priority and the threshold must not raise the line; an off-by-one compare would fire at the threshold itself. A notification that coincides with retiring the same priority must survive; a clear-wins design drops it. A byte read at the acknowledge offset must be harmless, since a decoder that ignores the access size would acknowledge by accident.

// File: rtl/thread_presenter.sv
module thread_presenter #(
  parameter int NPRIO = 8,
  parameter int AW    = 12,
  parameter logic [AW-1:0] ACK_OFS = 12'h800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ntf_valid,
  input  logic [$clog2(NPRIO)-1:0] ntf_prio,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic          bus_half,
  input  logic          bus_owner,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          irq_o
);
  localparam int PW = $clog2(NPRIO);
  localparam logic [1:0] EXC_PHYS = 2'b10;

  logic [7:0]       cppr;
  logic [NPRIO-1:0] ipb;
  logic [7:0]       pipr;
  logic             pending;
  logic [7:0]       nsr;

  always_comb begin
    pipr = 8'hFF;
    for (int i = NPRIO - 1; i >= 0; i--)
      if (ipb[i]) pipr = 8'(i);
  end

  assign pending = pipr < cppr;
  assign nsr     = pending ? {EXC_PHYS, 6'b0} : 8'h00;
  assign irq_o   = pending;

  wire own_acc  = bus_sel & bus_owner;
  wire is_ack   = own_acc & ~bus_we & bus_half & (bus_addr == ACK_OFS);
  wire ack_take = is_ack & pending;
  wire cppr_wr  = own_acc & bus_we &
                  ((~bus_half & (bus_addr == AW'(1))) | (bus_half & (bus_addr == AW'(0))));
  wire in_win   = (bus_addr >> 3) == '0;

  function automatic logic [7:0] win_byte(input logic [2:0] a);
    case (a)
      3'd0:    win_byte = nsr;
      3'd1:    win_byte = cppr;
      3'd2:    win_byte = 8'(ipb);
      3'd7:    win_byte = pipr;
      default: win_byte = 8'h00;
    endcase
  endfunction

  always_comb begin
    bus_rdata = 16'h0000;
    if (bus_sel && !bus_we) begin
      if (bus_addr == ACK_OFS) begin
        if (bus_half && bus_owner)
          bus_rdata = pending ? {EXC_PHYS, 6'b0, pipr} : {2'b00, 6'b0, cppr};
      end else if (in_win) begin
        if (!bus_half)
          bus_rdata = {8'h00, win_byte(bus_addr[2:0])};
        else if (!bus_addr[0])
          bus_rdata = {win_byte(bus_addr[2:0]), win_byte(bus_addr[2:0] | 3'd1)};
      end
    end
  end

  logic [NPRIO-1:0] clr_mask, set_mask;
  always_comb begin
    clr_mask = '0;
    set_mask = '0;
    if (ack_take) clr_mask[pipr[PW-1:0]] = 1'b1;
    if (ntf_valid) set_mask[ntf_prio] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr <= 8'h00;
      ipb  <= '0;
    end else begin
      ipb <= (ipb & ~clr_mask) | set_mask;
      if (ack_take)     cppr <= pipr;
      else if (cppr_wr) cppr <= bus_wdata[7:0];
    end
  end

  assert_notify_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |=> ipb[$past(ntf_prio)]);

  assert_irq_has_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($countones(ipb) != 0));

  assert_ack_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ack && irq_o) |=> (cppr == $past(pipr)));

  assert_idle_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ack && !irq_o && !ntf_valid) |=> ($stable(cppr) && $stable(ipb)));

  assert_foreign_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_owner && !ntf_valid) |=> ($stable(cppr) && $stable(ipb)));

  assert_coincide_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && ntf_valid && (8'(ntf_prio) == pipr)) |=> ipb[$past(ntf_prio)]);
endmodule

// File: tb/sim_thread_presenter.sv
module sim_thread_presenter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ntf_valid = 1'b0;
  logic [2:0] ntf_prio = '0;
  logic bus_sel = 1'b0, bus_we = 1'b0, bus_half = 1'b0, bus_owner = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_presenter u0 (
    .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_prio(ntf_prio),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_half(bus_half), .bus_owner(bus_owner),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  // {op[1:0], half, owner, addr[11:0], data[15:0], exp[15:0]}
  // op 0 = notify (prio in data), 1 = write, 2 = read and compare
  localparam int NV = 33;
  localparam logic [47:0] VEC [NV] = '{
    {2'd0,1'b0,1'b1,12'h000,16'h0005,16'h0000}, // R2 notify 5
    {2'd2,1'b0,1'b1,12'h002,16'h0000,16'h0020}, // R2
    {2'd2,1'b0,1'b1,12'h007,16'h0000,16'h0005}, // R3
    {2'd2,1'b0,1'b1,12'h000,16'h0000,16'h0000}, // R4 masked
    {2'd1,1'b0,1'b1,12'h001,16'h00FF,16'h0000}, // R7 open
    {2'd2,1'b0,1'b1,12'h000,16'h0000,16'h0080}, // R4
    {2'd2,1'b1,1'b1,12'h000,16'h0000,16'h80FF}, // R8 halfword
    {2'd0,1'b0,1'b1,12'h000,16'h0002,16'h0000}, // notify 2
    {2'd2,1'b1,1'b1,12'h006,16'h0000,16'h0002}, // R8 R3
    {2'd2,1'b1,1'b1,12'h800,16'h0000,16'h8002}, // R5 ack
    {2'd2,1'b0,1'b1,12'h001,16'h0000,16'h0002}, // R5
    {2'd2,1'b0,1'b1,12'h002,16'h0000,16'h0020}, // R5
    {2'd2,1'b0,1'b1,12'h000,16'h0000,16'h0000}, // R4
    {2'd2,1'b1,1'b1,12'h800,16'h0000,16'h0002}, // R6 idle ack
    {2'd2,1'b0,1'b1,12'h002,16'h0000,16'h0020}, // R6
    {2'd2,1'b0,1'b1,12'h001,16'h0000,16'h0002}, // R6
    {2'd1,1'b1,1'b1,12'h000,16'h12FF,16'h0000}, // R7 half write
    {2'd2,1'b1,1'b1,12'h000,16'h0000,16'h80FF}, // R7
    {2'd1,1'b0,1'b0,12'h001,16'h0003,16'h0000}, // R7 foreign write
    {2'd2,1'b0,1'b1,12'h001,16'h0000,16'h00FF}, // R7
    {2'd2,1'b1,1'b0,12'h800,16'h0000,16'h0000}, // R7 foreign ack
    {2'd2,1'b0,1'b1,12'h002,16'h0000,16'h0020}, // R7
    {2'd2,1'b1,1'b1,12'h800,16'h0000,16'h8005}, // R5
    {2'd2,1'b0,1'b1,12'h007,16'h0000,16'h00FF}, // R3 empty
    {2'd2,1'b0,1'b1,12'h003,16'h0000,16'h0000}, // R8
    {2'd2,1'b0,1'b1,12'h005,16'h0000,16'h0000}, // R8
    {2'd0,1'b0,1'b1,12'h000,16'h0000,16'h0000}, // notify 0
    {2'd1,1'b0,1'b1,12'h001,16'h0000,16'h0000}, // threshold 0
    {2'd2,1'b0,1'b1,12'h000,16'h0000,16'h0000}, // R4 equal not pending
    {2'd2,1'b0,1'b1,12'h800,16'h0000,16'h0000}, // R8 byte at ack ofs
    {2'd2,1'b0,1'b1,12'h002,16'h0000,16'h0001}, // R8 no side effect
    {2'd1,1'b0,1'b1,12'h001,16'h0001,16'h0000}, // threshold 1
    {2'd2,1'b0,1'b1,12'h000,16'h0000,16'h0080}  // R4
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input bit half, input bit own,
                        input logic [11:0] a, input logic [15:0] d,
                        input bit do_ntf, input logic [2:0] p,
                        output logic [15:0] rd);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_half = half; bus_owner = own;
    bus_addr = a; bus_wdata = d; ntf_valid = do_ntf; ntf_prio = p;
    #(CLK_PERIOD/4);
    rd = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0; ntf_valid = 1'b0;
  endtask

  task automatic notify(input logic [2:0] p);
    @(negedge clk);
    ntf_valid = 1'b1; ntf_prio = p;
    @(posedge clk); #1;
    ntf_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    access(0,0,1,12'h001,0,0,0,rd); check("R1 threshold", rd, 16'h0000);
    access(0,0,1,12'h002,0,0,0,rd); check("R1 bitmap", rd, 16'h0000);
    access(0,0,1,12'h007,0,0,0,rd); check("R1 pending prio", rd, 16'h00FF);
    access(0,0,1,12'h000,0,0,0,rd); check("R1 status", rd, 16'h0000);
    check("R1 irq", {15'b0, irq_o}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      case (v[47:46])
        2'd0: notify(v[18:16]);
        2'd1: access(1, v[45], v[44], v[43:32], v[31:16], 0, 0, rd);
        default: begin
          access(0, v[45], v[44], v[43:32], 0, 0, 0, rd);
          check($sformatf("vector %0d R-table", i), rd, v[15:0]);
        end
      endcase
    end

    // R4 line level: threshold 1, priority 0 pending
    @(negedge clk);
    check("R4 irq high", {15'b0, irq_o}, 16'h0001);

    // R9: acknowledge priority 0 while a new priority 0 arrives
    access(0,1,1,12'h800,0,1,3'd0,rd); check("R9 ack value", rd, 16'h8000);
    access(0,0,1,12'h002,0,0,0,rd); check("R9 bit kept", rd, 16'h0001);
    access(0,0,1,12'h001,0,0,0,rd); check("R9 threshold", rd, 16'h0000);
    @(negedge clk);
    check("R9 irq low", {15'b0, irq_o}, 16'h0000);

    // R1 reset mid-run clears everything
    notify(3'd6);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    access(0,0,1,12'h002,0,0,0,rd); check("R1 bitmap after reset", rd, 16'h0000);
    access(0,1,1,12'h800,0,0,0,rd); check("R1 R6 idle ack after reset", rd, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule